// File: doc/BRIEF.md
# Dual Down-Counting Timer with Reload

This peripheral holds two independent 32-bit down counters behind a small single-cycle register bus. Each counter moves by one on every clock in which the shared tick enable input is high and that counter is enabled. A counter runs in one of two modes. In periodic mode it reloads from its reload register each time it expires. In one-shot mode it expires once, stays at zero and disables itself.

Both timers are governed by one shared control word, which holds an enable bit and a reload bit for each. Software can read the live count at any time and can overwrite it. Only timer 1 is wired to an interrupt. That interrupt is a one-clock pulse for each expiry. This suits timer 0 to a free-running time base and timer 1 to event scheduling.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset every register reads zero and `irq_t1` is low.
- R2: The register map is: 0x00 control, 0x10 timer 0 reload, 0x14 timer 0 count, 0x18 timer 1 reload, 0x1c timer 1 count. Control bit 0 enables timer 0, bit 1 selects reload for timer 0, bit 2 enables timer 1, and bit 3 selects reload for timer 1. Control bits 31..4 read zero. Other offsets read zero, and writes to them change nothing.
- R3: An enabled timer with a nonzero count decrements by one on each clock with `tick_en` high. The count does not change on a clock without a tick.
- R4: A timer with reload selected that is at zero on a tick expires and takes its reload value. A reload value of N-1 therefore gives one expiry every N ticks.
- R5: A timer without reload that is at zero on a tick expires, stays at zero, and has its enable bit cleared by hardware. A control write in the same cycle takes precedence. A count of V gives its single expiry on the (V+1)th tick.
- R6: With reload value 0xFFFFFFFF and reload selected, a count at zero wraps to 0xFFFFFFFF and keeps running.
- R7: `irq_t1` is high for exactly the one clock after each edge at which timer 1 expires. Timer 0 never drives it.
- R8: A write to a count register loads the written value at that edge. The write takes precedence over any decrement and suppresses expiry in that cycle.
- R9: A timer whose enable bit is cleared holds its count from the next edge on.
- R10: The two timers are independent: activity on one never changes the other's count or reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one tick per high clock |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_t1 | output | 1 | Timer 1 expiry pulse |

## Verification
The bench targets the zero crossing. A design that reloads one tick early or late would show a period of N±1. A one-shot that fails to clear its enable bit would keep wrapping and firing. A count write that lands on the same tick as an expiry is driven on purpose: if the decrement wins, the written value comes back off by one, and a spurious pulse appears. Random mixes of writes to the reload, count and control registers, including unmapped offsets, expose any cross-coupling between the two timers. The same stimulus also shows a stopped timer that keeps moving.

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_t1
);
  localparam logic [AW-1:0] A_CTRL = AW'('h00);
  localparam logic [AW-1:0] A_RLD0 = AW'('h10);
  localparam logic [AW-1:0] A_VAL0 = AW'('h14);
  localparam logic [AW-1:0] A_RLD1 = AW'('h18);
  localparam logic [AW-1:0] A_VAL1 = AW'('h1c);

  logic [1:0]   en_q, rl_q, expire, wr_val, wr_rld;
  logic [W-1:0] cnt_q [2];
  logic [W-1:0] rld_q [2];
  logic         wr_ctrl;

  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_val  = {bus_wr && bus_addr == A_VAL1, bus_wr && bus_addr == A_VAL0};
  assign wr_rld  = {bus_wr && bus_addr == A_RLD1, bus_wr && bus_addr == A_RLD0};

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    assign expire[t] = tick_en && en_q[t] && cnt_q[t] == '0 && !wr_val[t];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[t] <= '0;
        rld_q[t] <= '0;
      end else begin
        if (wr_rld[t]) rld_q[t] <= bus_wdata;
        if (wr_val[t])
          cnt_q[t] <= bus_wdata;
        else if (tick_en && en_q[t]) begin
          if (cnt_q[t] != '0)  cnt_q[t] <= cnt_q[t] - 1'b1;
          else if (rl_q[t])    cnt_q[t] <= rld_q[t];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[t] <= 1'b0;
        rl_q[t] <= 1'b0;
      end else if (wr_ctrl) begin
        en_q[t] <= bus_wdata[2*t];
        rl_q[t] <= bus_wdata[2*t+1];
      end else if (expire[t] && !rl_q[t]) begin
        en_q[t] <= 1'b0;
      end
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && en_q[t] && cnt_q[t] != '0 && !wr_val[t]) |=> cnt_q[t] == $past(cnt_q[t]) - 1'b1); // R3
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && en_q[t] && rl_q[t] && cnt_q[t] == '0 && !wr_val[t] && !wr_rld[t])
      |=> cnt_q[t] == $past(rld_q[t])); // R4
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && en_q[t] && !rl_q[t] && cnt_q[t] == '0 && !wr_val[t] && !wr_ctrl)
      |=> (!en_q[t] && cnt_q[t] == '0)); // R5
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[t] && !wr_val[t]) |=> $stable(cnt_q[t])); // R9
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_val[t] |=> cnt_q[t] == $past(bus_wdata)); // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_t1 <= 1'b0;
    else        irq_t1 <= expire[1];
  end

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_t1 |-> $past(tick_en)); // R7

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(W-4){1'b0}}, rl_q[1], en_q[1], rl_q[0], en_q[0]};
      A_RLD0:  bus_rdata = rld_q[0];
      A_VAL0:  bus_rdata = cnt_q[0];
      A_RLD1:  bus_rdata = rld_q[1];
      A_VAL1:  bus_rdata = cnt_q[1];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/test_dual_countdown_timer.sv
`timescale 1ns/1ps
module test_dual_countdown_timer;
  logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_t1;
  int          n_chk = 0, n_bad = 0;

  logic [31:0] m_cnt [2];
  logic [31:0] m_rld [2];
  logic [1:0]  m_en, m_rl;
  logic        m_irq;

  always #2.5 clk = ~clk;

  dual_countdown_timer i_dual_countdown_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_t1(irq_t1));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {28'd0, m_rl[1], m_en[1], m_rl[0], m_en[0]};
      8'h10: return m_rld[0];
      8'h14: return m_cnt[0];
      8'h18: return m_rld[1];
      8'h1c: return m_cnt[1];
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_reset();
    for (int t = 0; t < 2; t++) begin m_cnt[t] = 0; m_rld[t] = 0; end
    m_en = 0; m_rl = 0; m_irq = 0;
  endtask

  // expected next state from the requirements
  task automatic m_step(input logic tk, input logic wr, input logic [7:0] a, input logic [31:0] d);
    logic [1:0] ex;
    for (int t = 0; t < 2; t++) begin
      logic wv;
      wv = wr && a == (t == 0 ? 8'h14 : 8'h1c);
      ex[t] = tk && m_en[t] && m_cnt[t] == 0 && !wv;
      if (wv) m_cnt[t] = d;
      else if (tk && m_en[t]) m_cnt[t] = (m_cnt[t] != 0) ? m_cnt[t] - 1 : (m_rl[t] ? m_rld[t] : 32'd0);
    end
    if (wr && a == 8'h10) m_rld[0] = d;
    if (wr && a == 8'h18) m_rld[1] = d;
    if (wr && a == 8'h00) begin m_en = {d[2], d[0]}; m_rl = {d[3], d[1]}; end
    else for (int t = 0; t < 2; t++) if (ex[t] && !m_rl[t]) m_en[t] = 1'b0;
    m_irq = ex[1];
  endtask

  task automatic cyc(input logic tk, input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tick_en = tk; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    chk("R2 read data vs model", bus_rdata, m_read(a));
    chk("R7 irq_t1 vs model", {31'd0, irq_t1}, {31'd0, m_irq});
    m_step(tk, wr, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    cyc(1'b0, 1'b0, a, 32'd0);
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pulses, last, gap_bad;
    void'($urandom(32'h5eed1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, 0, "R1 ctrl"); rd(8'h14, 0, "R1 val0"); rd(8'h1c, 0, "R1 val1");
    rd(8'h18, 0, "R1 rld1");
    chk("R1 irq low", {31'd0, irq_t1}, 32'd0);
    // R2 unused bits and unmapped offsets
    cyc(0, 1, 8'h00, 32'hFFFF_FFF0); rd(8'h00, 0, "R2 upper ctrl bits zero");
    cyc(0, 1, 8'h04, 32'h1234_5678); rd(8'h04, 0, "R2 unmapped reads zero");
    rd(8'h14, 0, "R2 unmapped write no effect");
    // R4/R7 periodic timer 1, reload 4 -> period 5
    cyc(0, 1, 8'h18, 4); cyc(0, 1, 8'h1c, 4); cyc(0, 1, 8'h00, 32'hC);
    pulses = 0; last = -1; gap_bad = 0;
    for (int i = 0; i < 26; i++) begin
      cyc(1, 0, 8'h1c, 0);
      if (irq_t1) begin
        if (last >= 0 && i - last != 5) gap_bad++;
        last = i; pulses++;
      end
    end
    chk("R4 periodic pulse count", pulses, 5);
    chk("R7 pulse spacing", gap_bad, 0);
    rd(8'h14, 0, "R10 timer0 untouched");
    // R9 stop
    cyc(0, 1, 8'h00, 0); cyc(1, 0, 8'h1c, 0);
    begin
      logic [31:0] held;
      held = bus_rdata;
      repeat (4) cyc(1, 0, 8'h1c, 0);
      chk("R9 stopped timer holds", bus_rdata, held);
    end
    // R5 one-shot timer 0, count 3 -> expiry on 4th tick
    cyc(0, 1, 8'h14, 3); cyc(0, 1, 8'h00, 1);
    repeat (3) cyc(1, 0, 8'h00, 0);
    chk("R5 enable still set before expiry", bus_rdata, 1);
    cyc(1, 0, 8'h00, 0); rd(8'h00, 0, "R5 enable cleared");
    repeat (3) cyc(1, 0, 8'h14, 0);
    chk("R5 holds at zero", bus_rdata, 0);
    // R6 wrap with all-ones reload
    cyc(0, 1, 8'h10, 32'hFFFF_FFFF); cyc(0, 1, 8'h14, 1); cyc(0, 1, 8'h00, 3);
    cyc(1, 0, 8'h14, 0); cyc(1, 0, 8'h14, 0); rd(8'h14, 32'hFFFF_FFFF, "R6 wrap");
    cyc(1, 0, 8'h14, 0); rd(8'h14, 32'hFFFF_FFFE, "R6 continues");
    // R8 write at zero with tick: write wins, no pulse
    cyc(0, 1, 8'h00, 32'h4); cyc(0, 1, 8'h1c, 0);
    cyc(1, 1, 8'h1c, 9);
    cyc(0, 0, 8'h1c, 0);
    chk("R8 written value kept", bus_rdata, 9);
    chk("R8 no pulse", {31'd0, irq_t1}, 0);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        w;
      int          s;
      s = $urandom_range(0, 6);
      a = (s == 0) ? 8'h00 : (s == 1) ? 8'h10 : (s == 2) ? 8'h14 : (s == 3) ? 8'h18 :
          (s == 4) ? 8'h1c : (s == 5) ? 8'h08 : 8'h20;
      w = $urandom_range(0, 9) == 0;
      d = ($urandom_range(0, 15) == 0) ? $urandom : 32'($urandom_range(0, 12));
      if (a == 8'h00 && w) d = $urandom;
      cyc($urandom_range(0, 1) == 1, w, a, d);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule